// File: doc/BRIEF.md
# Three-Way Write-Back Data Cache

This block is a small data cache for a processor with a 16-bit, byte-addressed address space. It holds 8 sets of three 32-byte lines. Each line carries an 8-bit tag, a valid bit and a dirty bit. Each set carries a 3-bit code that records the full recency order of its three ways. With these figures the whole tag store is 264 bits.

The processor presents one byte read or byte write at a time. It holds the request until the cache raises ready. A hit completes in the cycle it is presented. On a miss the cache picks a victim way. If that victim holds modified data, the whole line is first written out over a block-wide memory port. The missing block is then fetched, and the held request completes as a hit. Write misses allocate the line before the write is applied.

Top module: `cache3_top`

## Requirements
- R1: After reset every line is invalid, no memory request is raised, ready is low while no request is presented, and the first access to any address misses.
- R2: A read or write to a resident line completes with ready high in the same cycle it is presented, and a read returns the addressed byte on the read data port. The address splits into tag = bits 15:8, set = bits 7:5 and byte offset = bits 4:0.
- R3: A read miss fetches the block at address {tag, set, 5'b0} with a memory read (write-enable low), installs it, and then returns the requested byte. Byte k of a block travels on bits 8k+7:8k of the block-wide data buses.
- R4: A write hit changes only the addressed byte of the line and marks the line modified.
- R5: A write miss first allocates the line by fetching its block, then applies the byte write to it, so the line is resident and modified afterwards.
- R6: When a set has an invalid way, a miss fills the invalid way with the lowest index, and no valid line is evicted.
- R7: When all three ways are valid, a miss evicts the least recently used way, where every hit and every completed fill makes the accessed way most recent. The recency order is a 3-bit code per set that only takes the six legal values, and reset sets it to the order way 0, way 1, way 2 (way 2 least recent).
- R8: A modified victim is written out as a whole block at its own address {victim tag, set, 5'b0}, with write-enable high, before the read of the new block is issued; a clean victim causes no memory write.
- R9: Ready stays low for every cycle of a miss sequence, from the first miss cycle until the fill has completed.
- R10: A memory request, once raised, keeps its address and direction unchanged until the memory acknowledges it with a one-cycle ack pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Processor request present; held until ready |
| req_write | input | 1 | 1 = byte write, 0 = byte read |
| req_addr | input | 16 | Byte address of the request |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Request completes in this cycle |
| req_rdata | output | 8 | Read byte, valid while ready is high on a read |
| mem_req | output | 1 | Block transfer requested |
| mem_we | output | 1 | 1 = block write-back, 0 = block fetch |
| mem_addr | output | 16 | Block-aligned memory address |
| mem_wdata | output | 256 | Block written back |
| mem_ack | input | 1 | One-cycle completion of the memory transfer |
| mem_rdata | input | 256 | Fetched block, valid with ack |

## Verification
A write hit changes three things in the same cycle: it stores the byte, it sets the line's dirty bit, and it moves that way to the front of the recency order. The risk is that one of these three changes is lost. The bench provokes this case by writing into a line and then touching the two other ways of the set. This leaves the written way least recent. A further miss must then evict it. The check is that the evicted block is written back at the victim's address, carries the written byte, and is followed by the fetch, all compared against a behavioural model that tracks order, dirty state and line contents.

// File: rtl/cache3_pkg.sv
package cache3_pkg;
  localparam int N_WAYS = 3;
  localparam int LRU_W  = 3;

  typedef logic [1:0]       way_t;
  typedef logic [LRU_W-1:0] lru_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WBACK, ST_FILL} mstate_t;

  // Code c: most recent way = c/2; the other two ways in ascending order
  // are (lo, hi); c[0]==0 means lo is middle, c[0]==1 means hi is middle.
  localparam lru_t LRU_RESET = 3'd0;  // order 0,1,2

  function automatic way_t lru_mru(lru_t c);
    return way_t'(c[2:1]);
  endfunction

  function automatic way_t other_lo(way_t m);
    return (m == 2'd0) ? 2'd1 : 2'd0;
  endfunction

  function automatic way_t other_hi(way_t m);
    return (m == 2'd2) ? 2'd1 : 2'd2;
  endfunction

  function automatic way_t lru_last(lru_t c);
    way_t m;
    m = lru_mru(c);
    return c[0] ? other_lo(m) : other_hi(m);
  endfunction

  function automatic lru_t lru_encode(way_t first, way_t second);
    return {first, (second == other_hi(first))};
  endfunction

  function automatic lru_t lru_touch(lru_t c, way_t w);
    way_t m;
    m = lru_mru(c);
    if (w == m) return c;
    return lru_encode(w, m);
  endfunction
endpackage

// File: rtl/cache3_tags.sv
module cache3_tags
  import cache3_pkg::*;
#(
  parameter int SET_CNT = 8,
  parameter int IDX_W   = 3,
  parameter int TAG_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit,
  output way_t             hit_way,
  output way_t             vict_way,
  output logic             vict_valid,
  output logic             vict_dirty,
  output logic [TAG_W-1:0] vict_tag,
  input  logic             hit_upd,
  input  logic             hit_wr,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  way_t             fill_way,
  input  logic [TAG_W-1:0] fill_tag
);
  logic [TAG_W-1:0]  tag_q   [SET_CNT][N_WAYS];
  logic [N_WAYS-1:0] val_q   [SET_CNT];
  logic [N_WAYS-1:0] dirty_q [SET_CNT];
  lru_t              lru_q   [SET_CNT];

  logic [N_WAYS-1:0] hit_vec;
  logic [N_WAYS-1:0] cur_val;

  for (genvar w = 0; w < N_WAYS; w++) begin : g_cmp
    assign hit_vec[w] = val_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
  end

  assign hit     = |hit_vec;
  assign cur_val = val_q[lk_idx];

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < N_WAYS; w++)
      if (hit_vec[w]) hit_way = way_t'(w);
  end

  // Invalid ways first (lowest index), otherwise the least recent way.
  always_comb begin
    if (!cur_val[0])      vict_way = 2'd0;
    else if (!cur_val[1]) vict_way = 2'd1;
    else if (!cur_val[2]) vict_way = 2'd2;
    else                  vict_way = lru_last(lru_q[lk_idx]);
  end

  assign vict_valid = cur_val[vict_way];
  assign vict_dirty = dirty_q[lk_idx][vict_way];
  assign vict_tag   = tag_q[lk_idx][vict_way];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SET_CNT; s++) begin
        val_q[s]   <= '0;
        dirty_q[s] <= '0;
        lru_q[s]   <= LRU_RESET;
        for (int w = 0; w < N_WAYS; w++) tag_q[s][w] <= '0;
      end
    end else begin
      if (hit_upd) begin
        lru_q[lk_idx] <= lru_touch(lru_q[lk_idx], hit_way);
        if (hit_wr) dirty_q[lk_idx][hit_way] <= 1'b1;
      end
      if (fill_en) begin
        tag_q[fill_idx][fill_way]   <= fill_tag;
        val_q[fill_idx][fill_way]   <= 1'b1;
        dirty_q[fill_idx][fill_way] <= 1'b0;
        lru_q[fill_idx]             <= lru_touch(lru_q[fill_idx], fill_way);
      end
    end
  end

  for (genvar s = 0; s < SET_CNT; s++) begin : g_lru_chk
    AST_LRU_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      lru_q[s] < 3'd6);  // R7
  end

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));  // R2

  AST_WRHIT_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_upd && hit_wr) |=> dirty_q[$past(lk_idx)][$past(hit_way)]);  // R4

  AST_FILL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (val_q[$past(fill_idx)][$past(fill_way)] &&
                 tag_q[$past(fill_idx)][$past(fill_way)] == $past(fill_tag)));  // R3
endmodule

// File: rtl/cache3_data.sv
module cache3_data
  import cache3_pkg::*;
#(
  parameter int SET_CNT    = 8,
  parameter int LINE_BYTES = 32,
  parameter int IDX_W      = 3,
  parameter int OFF_W      = 5,
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  input  way_t              rd_way,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [7:0]        rd_byte,
  input  logic              byte_en,
  input  logic [7:0]        byte_wdata,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  way_t              fill_way,
  input  logic [LINE_W-1:0] fill_line,
  input  logic [IDX_W-1:0]  wb_idx,
  input  way_t              wb_way,
  output logic [LINE_W-1:0] wb_line
);
  logic [LINE_W-1:0] line_q [SET_CNT][N_WAYS];
  logic [OFF_W+2:0]  bit_pos;

  assign bit_pos = {rd_off, 3'b000};
  assign rd_byte = line_q[rd_idx][rd_way][bit_pos +: 8];
  assign wb_line = line_q[wb_idx][wb_way];

  always_ff @(posedge clk) begin
    if (fill_en)
      line_q[fill_idx][fill_way] <= fill_line;
    else if (byte_en)
      line_q[rd_idx][rd_way][bit_pos +: 8] <= byte_wdata;
  end
endmodule

// File: rtl/cache3_ctrl.sv
module cache3_ctrl
  import cache3_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 8,
  parameter int OFF_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic              hit,
  input  way_t              vict_way,
  input  logic              vict_valid,
  input  logic              vict_dirty,
  input  logic [TAG_W-1:0]  vict_tag,
  input  logic              mem_ack,
  output logic              req_ready,
  output logic              hit_upd,
  output logic              hit_wr,
  output logic              fill_en,
  output logic [IDX_W-1:0]  miss_idx,
  output way_t              miss_way,
  output logic [TAG_W-1:0]  miss_tag,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr
);
  mstate_t          st_q, st_d;
  logic [TAG_W-1:0] wb_tag_q;
  logic             miss_start;

  assign miss_start = (st_q == ST_IDLE) && req_valid && !hit;
  assign req_ready  = (st_q == ST_IDLE) && req_valid && hit;
  assign hit_upd    = req_ready;
  assign hit_wr     = req_ready && req_write;
  assign fill_en    = (st_q == ST_FILL) && mem_ack;

  assign mem_req  = (st_q != ST_IDLE);
  assign mem_we   = (st_q == ST_WBACK);
  assign mem_addr = {((st_q == ST_WBACK) ? wb_tag_q : miss_tag), miss_idx, {OFF_W{1'b0}}};

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (miss_start) st_d = (vict_valid && vict_dirty) ? ST_WBACK : ST_FILL;
      ST_WBACK: if (mem_ack)    st_d = ST_FILL;
      ST_FILL:  if (mem_ack)    st_d = ST_IDLE;
      default:                  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      miss_idx <= '0;
      miss_tag <= '0;
      miss_way <= '0;
      wb_tag_q <= '0;
    end else begin
      st_q <= st_d;
      if (miss_start) begin
        miss_idx <= lk_idx;
        miss_tag <= lk_tag;
        miss_way <= vict_way;
        wb_tag_q <= vict_tag;
      end
    end
  end

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));  // R10

  AST_NO_READY_IN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);  // R9

  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));  // R8
endmodule

// File: rtl/cache3_top.sv
module cache3_top
  import cache3_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int SET_CNT    = 8,
  parameter int LINE_BYTES = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [7:0]              req_wdata,
  output logic                    req_ready,
  output logic [7:0]              req_rdata,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [LINE_BYTES*8-1:0] mem_wdata,
  input  logic                    mem_ack,
  input  logic [LINE_BYTES*8-1:0] mem_rdata
);
  localparam int IDX_W  = $clog2(SET_CNT);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

  logic [TAG_W-1:0] lk_tag, vict_tag, miss_tag;
  logic [IDX_W-1:0] lk_idx, miss_idx;
  logic [OFF_W-1:0] lk_off;
  logic             hit, vict_valid, vict_dirty;
  logic             hit_upd, hit_wr, fill_en;
  way_t             hit_way, vict_way, miss_way;

  assign lk_tag = req_addr[ADDR_W-1 -: TAG_W];
  assign lk_idx = req_addr[OFF_W +: IDX_W];
  assign lk_off = req_addr[OFF_W-1:0];

  cache3_tags #(.SET_CNT(SET_CNT), .IDX_W(IDX_W), .TAG_W(TAG_W)) tags_i (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(lk_idx), .lk_tag(lk_tag),
    .hit(hit), .hit_way(hit_way),
    .vict_way(vict_way), .vict_valid(vict_valid), .vict_dirty(vict_dirty), .vict_tag(vict_tag),
    .hit_upd(hit_upd), .hit_wr(hit_wr),
    .fill_en(fill_en), .fill_idx(miss_idx), .fill_way(miss_way), .fill_tag(miss_tag)
  );

  cache3_data #(.SET_CNT(SET_CNT), .LINE_BYTES(LINE_BYTES), .IDX_W(IDX_W), .OFF_W(OFF_W)) data_i (
    .clk(clk),
    .rd_idx(lk_idx), .rd_way(hit_way), .rd_off(lk_off), .rd_byte(req_rdata),
    .byte_en(hit_wr), .byte_wdata(req_wdata),
    .fill_en(fill_en), .fill_idx(miss_idx), .fill_way(miss_way), .fill_line(mem_rdata),
    .wb_idx(miss_idx), .wb_way(miss_way), .wb_line(mem_wdata)
  );

  cache3_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .OFF_W(OFF_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .hit(hit),
    .vict_way(vict_way), .vict_valid(vict_valid), .vict_dirty(vict_dirty), .vict_tag(vict_tag),
    .mem_ack(mem_ack),
    .req_ready(req_ready), .hit_upd(hit_upd), .hit_wr(hit_wr), .fill_en(fill_en),
    .miss_idx(miss_idx), .miss_way(miss_way), .miss_tag(miss_tag),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr)
  );
endmodule

// File: tb/cache3_top_tb_top.sv
module cache3_top_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0;
  logic [15:0]  req_addr = '0;
  logic [7:0]   req_wdata = '0;
  logic         req_ready;
  logic [7:0]   req_rdata;
  logic         mem_req, mem_we;
  logic [15:0]  mem_addr;
  logic [255:0] mem_wdata;
  logic         mem_ack = 1'b0;
  logic [255:0] mem_rdata = '0;

  always #4 clk = ~clk;

  cache3_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .req_rdata(req_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  // Behavioural reference: main memory plus cache model.
  logic [7:0] mem_b  [0:65535];
  logic [7:0] m_line [0:7][0:2][0:31];
  logic [7:0] m_tag  [0:7][0:2];
  bit         m_val  [0:7][0:2];
  bit         m_dirty[0:7][0:2];
  int         m_ord  [0:7][0:2];

  bit           ev_we[$];
  logic [15:0]  ev_addr[$];
  logic [255:0] ev_data[$];

  // Memory responder: ack two cycles after a request appears.
  int          lat = 0;
  bit          holding = 0;
  logic [15:0] hold_addr;
  bit          hold_we;
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; lat = 0; holding = 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0; lat = 0; holding = 0;
    end else if (mem_req) begin
      if (holding) chk(mem_addr == hold_addr && mem_we == hold_we, "R10", mem_addr, hold_addr);
      else begin holding = 1; hold_addr = mem_addr; hold_we = mem_we; end
      if (lat == 2) begin
        mem_ack <= 1'b1;
        ev_we.push_back(mem_we);
        ev_addr.push_back(mem_addr);
        ev_data.push_back(mem_wdata);
        for (int b = 0; b < 32; b++) begin
          if (mem_we) mem_b[mem_addr + b] = mem_wdata[b*8 +: 8];
          else        mem_rdata[b*8 +: 8] <= mem_b[mem_addr + b];
        end
      end else lat++;
    end
  end

  task automatic touch(input int s, input int w);
    int p;
    p = 0;
    for (int k = 0; k < 3; k++) if (m_ord[s][k] == w) p = k;
    for (int k = p; k > 0; k--) m_ord[s][k] = m_ord[s][k-1];
    m_ord[s][0] = w;
  endtask

  task automatic access(input bit wr, input logic [15:0] a, input logic [7:0] wd, input string rq);
    logic [2:0]   s;
    logic [7:0]   t;
    logic [4:0]   o;
    int           hw, vw, n_ev, samples, rd_seen;
    bit           exp_hit, exp_wb, got, any_rd, er;
    logic [7:0]   rd_s;
    logic [255:0] el;
    s = a[7:5]; t = a[15:8]; o = a[4:0];
    hw = -1;
    for (int w = 0; w < 3; w++) if (m_val[s][w] && m_tag[s][w] == t) hw = w;
    exp_hit = (hw >= 0);
    vw = -1;
    for (int w = 2; w >= 0; w--) if (!m_val[s][w]) vw = w;
    if (vw < 0) vw = m_ord[s][2];
    exp_wb = !exp_hit && m_val[s][vw] && m_dirty[s][vw];
    ev_we.delete(); ev_addr.delete(); ev_data.delete();
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    #1;
    samples = 0; rd_seen = 0; got = 0; rd_s = '0;
    while (!got && samples < 400) begin
      any_rd = 0;
      foreach (ev_we[i]) if (!ev_we[i]) any_rd = 1;
      if (any_rd) rd_seen++;
      er = exp_hit || (rd_seen >= 2);
      chk(req_ready == er, exp_hit ? rq : "R9", req_ready, er);
      if (req_ready) begin got = 1; rd_s = req_rdata; end
      else begin @(negedge clk); #1; end
      samples++;
    end
    if (!got) chk(0, "R9", 0, 1);
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (exp_hit) chk(ev_we.size() == 0, rq, ev_we.size(), 0);
    else begin
      n_ev = exp_wb ? 2 : 1;
      chk(ev_we.size() == n_ev, "R8", ev_we.size(), n_ev);
      if (ev_we.size() == n_ev) begin
        if (exp_wb) begin
          for (int b = 0; b < 32; b++) el[b*8 +: 8] = m_line[s][vw][b];
          chk(ev_we[0] && ev_addr[0] == {m_tag[s][vw], s, 5'b0}, "R8", ev_addr[0], {m_tag[s][vw], s, 5'b0});
          chk(ev_data[0] == el, "R8", ev_data[0][31:0], el[31:0]);
        end
        chk(!ev_we[n_ev-1] && ev_addr[n_ev-1] == {t, s, 5'b0}, "R3", ev_addr[n_ev-1], {t, s, 5'b0});
      end
      for (int b = 0; b < 32; b++) m_line[s][vw][b] = mem_b[{t, s, 5'(b)}];
      m_tag[s][vw] = t; m_val[s][vw] = 1; m_dirty[s][vw] = 0;
      touch(s, vw);
      hw = vw;
    end
    if (wr) begin
      m_line[s][hw][o] = wd; m_dirty[s][hw] = 1;
    end else chk(rd_s == m_line[s][hw][o], rq, rd_s, m_line[s][hw][o]);
    touch(s, hw);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R9 watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 65536; i++) mem_b[i] = 8'((i * 7) ^ ((i >> 8) * 13));
    for (int s = 0; s < 8; s++)
      for (int w = 0; w < 3; w++) begin
        m_val[s][w] = 0; m_dirty[s][w] = 0; m_ord[s][w] = w; m_tag[s][w] = '0;
      end
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready == 1'b0 && mem_req == 1'b0, "R1", {req_ready, mem_req}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk(req_ready == 1'b0 && mem_req == 1'b0, "R1", {req_ready, mem_req}, 0);

    // set 2 directed sequence
    access(0, {8'h01, 3'd2, 5'd5}, 8'h00, "R1");   // cold miss, way 0
    access(0, {8'h01, 3'd2, 5'd9}, 8'h00, "R2");   // hit
    access(1, {8'h01, 3'd2, 5'd9}, 8'hA5, "R4");   // write hit, dirty
    access(0, {8'h01, 3'd2, 5'd9}, 8'h00, "R4");   // reads back A5
    access(0, {8'h02, 3'd2, 5'd0}, 8'h00, "R6");   // fills way 1
    access(0, {8'h03, 3'd2, 5'd31}, 8'h00, "R6");  // fills way 2
    access(0, {8'h01, 3'd2, 5'd9}, 8'h00, "R6");   // all three resident
    access(0, {8'h02, 3'd2, 5'd1}, 8'h00, "R7");
    access(0, {8'h03, 3'd2, 5'd2}, 8'h00, "R7");   // tag 01 now least recent, dirty
    access(0, {8'h04, 3'd2, 5'd3}, 8'h00, "R8");   // dirty eviction
    access(1, {8'h05, 3'd2, 5'd0}, 8'h3C, "R5");   // write miss, clean victim
    access(0, {8'h05, 3'd2, 5'd0}, 8'h00, "R5");
    access(0, {8'h01, 3'd2, 5'd9}, 8'h00, "R8");   // written-back byte returns
    access(0, {8'h03, 3'd2, 5'd2}, 8'h00, "R7");

    for (int i = 0; i < 300; i++)
      access($urandom_range(0, 2) == 0, {8'($urandom_range(0, 5)), 3'($urandom_range(0, 7)), 5'($urandom_range(0, 31))},
             8'($urandom), "R7");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule